// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

The block overlays a square two-plane cursor image onto a pixel stream. A raster timing source outside the block supplies the current horizontal and vertical pixel coordinates together with a pixel-valid strobe and a one-cycle start-of-frame pulse. For every valid pixel the block checks whether the coordinate falls inside the cursor window. It returns a visibility flag and the cursor pixel bit for that location one clock later. The downstream colour stage then chooses between the cursor colours and the underlying picture.

Software loads three things through a simple write port: a packed signed X/Y position, one mask word per cursor row and one pattern word per cursor row. All of these go into shadow registers. They are copied into the active set on the start-of-frame pulse, so a frame never shows a half-updated cursor. The block has no enable bit. The cursor is hidden by placing it at (-32,-32), which puts the whole window above and to the left of the screen. Because the coordinates are signed, the cursor can also sit partly off the top or left edge and be clipped cleanly.

Top module: `cur_overlay`

## Requirements
- R1: After reset both outputs are 0 and the position is (-32,-32) in both the shadow and the active set. With no position write, no pixel is visible, even after a start-of-frame pulse.
- R2: A write to address 0 loads the position. Bits 31:16 hold X and bits 15:0 hold Y, each a 16-bit two's-complement value.
- R3: A write to address 0x40+r loads mask row r, and a write to address 0x60+r loads pattern row r, for r in 0..31.
- R4: Writes land in shadow registers only. The active position and image change only on the clock edge where frame_start_i is 1. They take effect for pixels presented after that edge, and remain unchanged at every other edge.
- R5: A raster pixel (hx,vy) is inside the window when cx <= hx < cx+32 and cy <= vy < cy+32. The comparison is signed, so negative cx or cy clip the cursor at the left or top edge.
- R6: Inside the window, the row index is vy-cy and the column index is hx-cx. Column 0 is bit 31 of the row word and column 31 is bit 0.
- R7: cur_vis_o is 1 only when the pixel is valid, inside the window, and its mask bit is 1. cur_pix_o equals the pattern bit when cur_vis_o is 1, and is 0 otherwise.
- R8: Both outputs are registered. A pixel presented before a clock edge appears on the outputs after that same edge.
- R9: When pix_valid_i is 0, both outputs are 0 after the next edge, whatever the coordinates.
- R10: Writes to addresses 1 to 0x3F change neither the position nor the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Register write address |
| wr_data_i | input | 32 | Register write data |
| frame_start_i | input | 1 | One-cycle start-of-frame pulse, copies shadow to active |
| pix_valid_i | input | 1 | Current raster pixel is active |
| hpos_i | input | 16 | Raster horizontal coordinate, unsigned |
| vpos_i | input | 16 | Raster vertical coordinate, unsigned |
| cur_vis_o | output | 1 | Cursor covers this pixel |
| cur_pix_o | output | 1 | Cursor pattern bit for this pixel |

## Verification
The hardest cases to reach from the ports are the signed window edges. A pixel at screen coordinate 0 must map to a column or row deep inside the cursor image when the position is negative, and the pixel one past cx+31 must fall outside. The bench programs negative positions such as (-5,-3) and probes the first and last covered pixels on each axis. It uses row words whose bits differ by row and column, so that an off-by-one in either index, or a reversed bit order, shows up as a wrong output bit. Double buffering is checked by probing after a write but before the frame pulse, and again after the pulse.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int CUR_CW = 16;

  typedef struct packed {
    logic signed [CUR_CW-1:0] x;
    logic signed [CUR_CW-1:0] y;
  } cur_pos_t;
endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cur_pkg::*;
#(
  parameter int DIM = 32,
  parameter int AW  = 7,
  parameter int DW  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic                          frame_start_i,
  output cur_pos_t                      act_pos_o,
  output logic [DIM-1:0][DIM-1:0]       act_mask_o,
  output logic [DIM-1:0][DIM-1:0]       act_pat_o
);
  localparam int RAW = $clog2(DIM);
  localparam logic signed [CUR_CW-1:0] HIDE = CUR_CW'(-DIM);

  cur_pos_t             sh_pos;
  logic [DIM-1:0][DIM-1:0] sh_mask, sh_pat;

  logic img_sel, pat_sel, pos_we;
  logic [RAW-1:0] row_sel;
  assign img_sel = wr_addr_i[AW-1];
  assign pat_sel = wr_addr_i[AW-2];
  assign row_sel = wr_addr_i[RAW-1:0];
  assign pos_we  = wr_en_i && (wr_addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_pos    <= '{x: HIDE, y: HIDE};
      act_pos_o <= '{x: HIDE, y: HIDE};
    end else begin
      if (pos_we) sh_pos <= wr_data_i[2*CUR_CW-1:0];
      if (frame_start_i) act_pos_o <= sh_pos;
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic row_hit;
    assign row_hit = wr_en_i && img_sel && (row_sel == RAW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_mask[r]    <= '0;
        sh_pat[r]     <= '0;
        act_mask_o[r] <= '0;
        act_pat_o[r]  <= '0;
      end else begin
        if (row_hit && !pat_sel) sh_mask[r] <= wr_data_i[DW-1 -: DIM];
        if (row_hit &&  pat_sel) sh_pat[r]  <= wr_data_i[DW-1 -: DIM];
        if (frame_start_i) begin
          act_mask_o[r] <= sh_mask[r];
          act_pat_o[r]  <= sh_pat[r];
        end
      end
    end
  end
endmodule

// File: rtl/cur_hit.sv
module cur_hit
  import cur_pkg::*;
#(
  parameter int DIM = 32
) (
  input  cur_pos_t                  pos_i,
  input  logic [CUR_CW-1:0]         hpos_i,
  input  logic [CUR_CW-1:0]         vpos_i,
  output logic                      hit_o,
  output logic [$clog2(DIM)-1:0]    row_o,
  output logic [$clog2(DIM)-1:0]    col_o
);
  localparam int RAW = $clog2(DIM);
  localparam int EW  = CUR_CW + 2;

  logic signed [EW-1:0] dx, dy;
  logic in_x, in_y;

  // raster is unsigned, cursor is signed; widen both before subtracting
  assign dx = $signed({2'b00, hpos_i}) - $signed({{2{pos_i.x[CUR_CW-1]}}, pos_i.x});
  assign dy = $signed({2'b00, vpos_i}) - $signed({{2{pos_i.y[CUR_CW-1]}}, pos_i.y});

  assign in_x  = (dx[EW-1:RAW] == '0);
  assign in_y  = (dy[EW-1:RAW] == '0);
  assign hit_o = in_x && in_y;
  assign col_o = dx[RAW-1:0];
  assign row_o = dy[RAW-1:0];
endmodule

// File: rtl/cur_pix.sv
module cur_pix #(
  parameter int DIM = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pix_valid_i,
  input  logic                      hit_i,
  input  logic [$clog2(DIM)-1:0]    row_i,
  input  logic [$clog2(DIM)-1:0]    col_i,
  input  logic [DIM-1:0][DIM-1:0]   mask_i,
  input  logic [DIM-1:0][DIM-1:0]   pat_i,
  output logic                      vis_o,
  output logic                      pix_o
);
  localparam int RAW = $clog2(DIM);

  logic [RAW-1:0] bit_idx;
  logic mask_bit, pat_bit, vis_d;

  // column 0 is the MSB of the row word
  assign bit_idx  = RAW'(DIM-1) - col_i;
  assign mask_bit = mask_i[row_i][bit_idx];
  assign pat_bit  = pat_i[row_i][bit_idx];
  assign vis_d    = pix_valid_i && hit_i && mask_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_o <= 1'b0;
      pix_o <= 1'b0;
    end else begin
      vis_o <= vis_d;
      pix_o <= vis_d && pat_bit;
    end
  end
endmodule

// File: rtl/cur_overlay.sv
module cur_overlay
  import cur_pkg::*;
#(
  parameter int DIM = 32,
  parameter int DW  = 2*CUR_CW,
  parameter int AW  = $clog2(DIM) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              frame_start_i,
  input  logic              pix_valid_i,
  input  logic [CUR_CW-1:0] hpos_i,
  input  logic [CUR_CW-1:0] vpos_i,
  output logic              cur_vis_o,
  output logic              cur_pix_o
);
  localparam int RAW = $clog2(DIM);

  cur_pos_t                act_pos;
  logic [DIM-1:0][DIM-1:0] act_mask, act_pat;
  logic                    hit;
  logic [RAW-1:0]          row, col;

  cur_regs #(.DIM(DIM), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .frame_start_i,
    .act_pos_o(act_pos), .act_mask_o(act_mask), .act_pat_o(act_pat)
  );

  cur_hit #(.DIM(DIM)) u_hit (
    .pos_i(act_pos), .hpos_i, .vpos_i, .hit_o(hit), .row_o(row), .col_o(col)
  );

  cur_pix #(.DIM(DIM)) u_pix (
    .clk_i, .rst_ni, .pix_valid_i, .hit_i(hit), .row_i(row), .col_i(col),
    .mask_i(act_mask), .pat_i(act_pat), .vis_o(cur_vis_o), .pix_o(cur_pix_o)
  );
endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk
  import cur_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     frame_start_i,
  input logic     pix_valid_i,
  input logic     hit,
  input cur_pos_t act_pos,
  input logic     cur_vis_o,
  input logic     cur_pix_o
);
  assert_pix_in_vis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_pix_o |-> cur_vis_o);

  assert_vis_needs_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !cur_vis_o);

  assert_vis_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !cur_vis_o);

  assert_pos_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_pos));
endmodule

bind cur_overlay cur_overlay_chk u_chk (
  .clk_i, .rst_ni, .frame_start_i, .pix_valid_i, .hit, .act_pos, .cur_vis_o, .cur_pix_o
);

// File: tb/tb_cur_overlay.sv
`timescale 1ns/100ps
module tb_cur_overlay;
  logic        clk_i = 0, rst_ni = 0;
  logic        wr_en_i = 0, frame_start_i = 0, pix_valid_i = 0;
  logic [6:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] hpos_i = '0, vpos_i = '0;
  logic        cur_vis_o, cur_pix_o;

  int tests = 0, fails = 0;
  int sx = -32, sy = -32, ax = -32, ay = -32;
  logic [31:0] smask [32], spat [32], amask [32], apat [32];

  always #2.5 clk_i = ~clk_i;

  cur_overlay dut (.*);

  task automatic chk(logic got, logic exp, string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic set_pos(int x, int y);  // R2: X in 31:16, Y in 15:0
    wr(7'h00, {x[15:0], y[15:0]}); sx = x; sy = y;
  endtask

  task automatic load_img();  // R3: mask at 0x40+r, pattern at 0x60+r
    for (int r = 0; r < 32; r++) begin
      smask[r] = ~(32'h1 << r) ^ (32'h0000_0100 << (r % 8));
      spat[r]  = 32'hA5C3_0F96 ^ (32'h0101_0101 * r);
      wr(7'h40 | 7'(r), smask[r]);
      wr(7'h60 | 7'(r), spat[r]);
    end
  endtask

  task automatic frame();
    @(negedge clk_i); frame_start_i = 1;
    @(negedge clk_i); frame_start_i = 0;
    ax = sx; ay = sy;
    for (int r = 0; r < 32; r++) begin amask[r] = smask[r]; apat[r] = spat[r]; end
  endtask

  // R8: drive before an edge, sample at the following falling edge
  task automatic probe(int hx, int vy, logic valid, string req);
    int dx, dy; logic m, p;
    dx = hx - ax; dy = vy - ay; m = 0; p = 0;
    if (valid && dx >= 0 && dx < 32 && dy >= 0 && dy < 32) begin
      m = amask[dy][31-dx]; p = m & apat[dy][31-dx];
    end
    @(negedge clk_i); pix_valid_i = valid; hpos_i = 16'(hx); vpos_i = 16'(vy);
    @(negedge clk_i); pix_valid_i = 0;
    chk(cur_vis_o, m, {req, " vis"});
    chk(cur_pix_o, p, {req, " pix"});
  endtask

  task automatic t_reset();
    chk(cur_vis_o, 0, "R1 reset vis");
    chk(cur_pix_o, 0, "R1 reset pix");
    load_img(); frame();
    probe(0, 0, 1, "R1 hidden");
    probe(5, 5, 1, "R1 hidden");
  endtask

  task automatic t_buffer();
    set_pos(100, 50);
    probe(100, 50, 1, "R4 before frame");
    probe(110, 60, 1, "R4 before frame");
    frame();
    probe(100, 50, 1, "R4 after frame");
    probe(50, 100, 1, "R2 axis order");
  endtask

  task automatic t_edges();
    probe(99, 60, 1, "R5 left out");
    probe(131, 60, 1, "R5 right in");
    probe(132, 60, 1, "R5 right out");
    probe(110, 49, 1, "R5 top out");
    probe(110, 81, 1, "R5 bottom in");
    probe(110, 82, 1, "R5 bottom out");
  endtask

  task automatic t_bits();
    for (int c = 0; c < 32; c += 3) probe(100 + c, 50 + (c % 32), 1, "R6 col/row");
    for (int r = 0; r < 32; r += 5) probe(100 + 7, 50 + r, 1, "R7 mask/pattern");
  endtask

  task automatic t_clip();
    set_pos(-5, -3); frame();
    probe(0, 0, 1, "R5 clip origin");
    probe(26, 28, 1, "R5 clip far corner");
    probe(27, 0, 1, "R5 clip past right");
    probe(0, 29, 1, "R5 clip past bottom");
    probe(3, 2, 1, "R6 clipped index");
  endtask

  task automatic t_valid();
    probe(0, 0, 0, "R9 invalid");
    probe(3, 2, 0, "R9 invalid");
  endtask

  task automatic t_ignore();
    wr(7'h01, 32'h0000_0000);
    wr(7'h3F, 32'h0000_0000);
    wr(7'h20, 32'hFFFF_FFFF);
    frame();
    probe(0, 0, 1, "R10 ignored");
    probe(26, 28, 1, "R10 ignored");
    probe(40, 40, 1, "R10 ignored");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin smask[r] = 0; spat[r] = 0; amask[r] = 0; apat[r] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_buffer();
    t_edges();
    t_bits();
    t_clip();
    t_valid();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule